// File: doc/BRIEF.md
# Fixed-Latency Load Return Buffer

This block sits between an in-order pipeline and a memory whose load response time varies. Software programs a 4-bit latency value, and from then on every load the block accepts hands its data back to the pipeline a fixed number of cycles after it was accepted. The compiler can then schedule the consumer of each load exactly that far away. The value is not affected by how fast the memory actually answered.

Each accepted load is given a slot in an eight-entry ring and a due time on an internal time base. The load goes out to memory at once, carrying the slot number as its tag. Memory may answer in any order. Data that arrives early waits in its slot. When the oldest load reaches its due time without data, the block raises a stall and freezes its time base until the data lands. A freeze keeps the spacing between all the loads still outstanding. Results always leave in acceptance order, one per cycle at most.

Top module: `fixed_latency_load_buffer`

## Requirements
- R1: After reset no result is presented, stall is low, issue is ready, the effective latency is 1, and the first tag handed out is 0.
- R2: The latency register holds a 4-bit value, and a written value of 0 behaves as 1. A write changes only the loads accepted in later cycles. A load accepted in the same cycle as the write still uses the old value.
- R3: A load accepted with effective latency L, whose response arrives at least one cycle before its due cycle and which sees no stall in between, produces wb_valid exactly L cycles after acceptance. It carries its own destination and data.
- R4: Data that arrives early is held and not presented before the due cycle, however early it came.
- R5: If the oldest load has no data in its due cycle, stall is high from that cycle through the cycle in which its response arrives. wb_valid for that load is high in the next cycle, while stall is low. A response that arrives exactly in the due cycle still costs one stall cycle.
- R6: Responses may come in any order and are matched by tag. Results are written back strictly in acceptance order.
- R7: Every stall cycle delays the result of every outstanding load by one cycle.
- R8: At most 8 loads are outstanding. While 8 are held, iss_ready is low, and an offered load produces no memory request.
- R9: iss_ready is low during every stall cycle.
- R10: An accepted load raises mreq_valid in the same cycle, with mreq_addr equal to iss_addr. The tags run 0,1,2,...,7,0,... in acceptance order.
- R11: After the latency is reduced, a load is due at the later of (acceptance plus its latency) and (the previous load's due time plus one), counted on the time base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lat_we | input | 1 | Latency register write strobe |
| lat_wdata | input | LAT_W | New latency value |
| iss_valid | input | 1 | Pipeline offers a load |
| iss_dest | input | DEST_W | Destination register of the load |
| iss_addr | input | ADDR_W | Load address |
| iss_ready | output | 1 | Load is accepted this cycle if offered |
| mreq_valid | output | 1 | Memory request strobe |
| mreq_addr | output | ADDR_W | Memory request address |
| mreq_tag | output | TAG_W | Slot tag for the request |
| mrsp_valid | input | 1 | Memory response strobe |
| mrsp_tag | input | TAG_W | Tag of the returning load |
| mrsp_data | input | DATA_W | Returned data |
| wb_valid | output | 1 | Result written back this cycle |
| wb_dest | output | DEST_W | Result destination |
| wb_data | output | DATA_W | Result data |
| stall | output | 1 | Pipeline must hold |

## Verification
The hardest situation to reach is a stall that strikes while younger loads are already waiting with their data. That case needs the oldest load starved while the younger ones are answered, and it is the only way to see the frozen time base shift the younger results. Directed sequences set it up on purpose. They also cover a full ring answered in reverse order, and a latency cut between two back-to-back loads. A long random phase then mixes latency writes, issue attempts and responses to randomly chosen open slots, and a bench model predicts every output on every cycle.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

  // Effective latency: a programmed zero is treated as one cycle.
  function automatic int unsigned eff_lat(input int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  // Offset from now to the due time of a newly accepted load.
  // It keeps dues strictly increasing after a latency reduction.
  function automatic int unsigned due_offset(input int unsigned lat,
                                             input bit has_prev,
                                             input int unsigned prev_rel);
    if (has_prev && (prev_rel + 1 > lat)) return prev_rel + 1;
    return lat;
  endfunction

  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  function automatic int unsigned ptr_prev(input int unsigned p, input int unsigned depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

endpackage

// File: rtl/lrb_latency_reg.sv
module lrb_latency_reg #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LAT_W-1:0] wdata,
  output logic [LAT_W-1:0] lat_eff
);
  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lat_q <= LAT_W'(1);
    else if (we) lat_q <= LAT_W'(lrb_pkg::eff_lat(32'(wdata)));
  end

  assign lat_eff = lat_q;

  // R2
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(lat_eff));

  // R2
  lat_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we && (wdata == '0) |=> (lat_eff == LAT_W'(1)));
endmodule

// File: rtl/lrb_timebase.sv
module lrb_timebase #(
  parameter int TIME_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output logic [TIME_W-1:0] now
);
  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else if (advance) now <= now + TIME_W'(1);
  end

  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(now));
endmodule

// File: rtl/lrb_slot_store.sv
module lrb_slot_store #(
  parameter int DEPTH  = 8,
  parameter int DEST_W = 5,
  parameter int DATA_W = 32,
  parameter int TIME_W = 6,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DEST_W-1:0] push_dest,
  input  logic [TIME_W-1:0] push_due,
  output logic [TAG_W-1:0]  push_tag,
  input  logic              pop,
  input  logic              fill,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  output logic [DEST_W-1:0] head_dest,
  output logic [DATA_W-1:0] head_data,
  output logic [TIME_W-1:0] head_due,
  output logic              head_filled,
  output logic [TIME_W-1:0] last_due,
  output logic [CNT_W-1:0]  count,
  output logic              full
);
  logic [TAG_W-1:0]  rd_ptr, wr_ptr;
  logic [DEPTH-1:0]  vld, fil;
  logic [DEPTH-1:0]  take, drop, land;
  logic [DEST_W-1:0] dst_m [DEPTH];
  logic [DATA_W-1:0] dat_m [DEPTH];
  logic [TIME_W-1:0] due_m [DEPTH];

  // Per-slot event decode.
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    assign take[s] = push && (wr_ptr == TAG_W'(s));
    assign drop[s] = pop  && (rd_ptr == TAG_W'(s));
    assign land[s] = fill && (fill_tag == TAG_W'(s));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      fil <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (take[s]) begin
          vld[s] <= 1'b1;
          fil[s] <= 1'b0;
        end else begin
          if (drop[s]) vld[s] <= 1'b0;
          if (land[s]) fil[s] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (take[s]) begin
        dst_m[s] <= push_dest;
        due_m[s] <= push_due;
      end
      if (land[s]) dat_m[s] <= fill_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= TAG_W'(lrb_pkg::ptr_next(32'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= TAG_W'(lrb_pkg::ptr_next(32'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign push_tag    = wr_ptr;
  assign head_dest   = dst_m[rd_ptr];
  assign head_data   = dat_m[rd_ptr];
  assign head_due    = due_m[rd_ptr];
  assign head_filled = fil[rd_ptr];
  assign last_due    = due_m[TAG_W'(lrb_pkg::ptr_prev(32'(wr_ptr), DEPTH))];
  assign full        = (count == CNT_W'(DEPTH));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

  // R6
  fill_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill |-> (vld[fill_tag] && !fil[fill_tag]));

  // R3
  pop_filled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (vld[rd_ptr] && fil[rd_ptr]));
endmodule

// File: rtl/fixed_latency_load_buffer.sv
module fixed_latency_load_buffer #(
  parameter int DEPTH  = 8,
  parameter int DEST_W = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int LAT_W  = 4,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lat_we,
  input  logic [LAT_W-1:0]  lat_wdata,
  input  logic              iss_valid,
  input  logic [DEST_W-1:0] iss_dest,
  input  logic [ADDR_W-1:0] iss_addr,
  output logic              iss_ready,
  output logic              mreq_valid,
  output logic [ADDR_W-1:0] mreq_addr,
  output logic [TAG_W-1:0]  mreq_tag,
  input  logic              mrsp_valid,
  input  logic [TAG_W-1:0]  mrsp_tag,
  input  logic [DATA_W-1:0] mrsp_data,
  output logic              wb_valid,
  output logic [DEST_W-1:0] wb_dest,
  output logic [DATA_W-1:0] wb_data,
  output logic              stall
);
  localparam int TIME_W = LAT_W + 2;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [LAT_W-1:0]  lat_eff;
  logic [TIME_W-1:0] now;
  logic [TIME_W-1:0] head_due, last_due, push_due, prev_rel;
  logic [DEST_W-1:0] head_dest;
  logic [DATA_W-1:0] head_data;
  logic              head_filled, full, has_any;
  logic [CNT_W-1:0]  count;
  logic [TAG_W-1:0]  push_tag;

  // Named internal events.
  logic head_due_now, stall_ev, wb_ev, iss_ev;

  lrb_latency_reg #(.LAT_W(LAT_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .we(lat_we), .wdata(lat_wdata), .lat_eff(lat_eff)
  );

  lrb_timebase #(.TIME_W(TIME_W)) u_time (
    .clk(clk), .rst_n(rst_n), .advance(!stall_ev), .now(now)
  );

  lrb_slot_store #(
    .DEPTH(DEPTH), .DEST_W(DEST_W), .DATA_W(DATA_W), .TIME_W(TIME_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(iss_ev), .push_dest(iss_dest), .push_due(push_due), .push_tag(push_tag),
    .pop(wb_ev),
    .fill(mrsp_valid), .fill_tag(mrsp_tag), .fill_data(mrsp_data),
    .head_dest(head_dest), .head_data(head_data), .head_due(head_due),
    .head_filled(head_filled), .last_due(last_due), .count(count), .full(full)
  );

  assign has_any      = (count != '0);
  assign head_due_now = has_any && (head_due == now);
  assign stall_ev     = head_due_now && !head_filled;
  assign wb_ev        = head_due_now && head_filled;
  assign iss_ready    = !full && !stall_ev;
  assign iss_ev       = iss_valid && iss_ready;

  assign prev_rel = last_due - now;
  assign push_due = now + TIME_W'(lrb_pkg::due_offset(32'(lat_eff), has_any, 32'(prev_rel)));

  assign mreq_valid = iss_ev;
  assign mreq_addr  = iss_addr;
  assign mreq_tag   = push_tag;
  assign wb_valid   = wb_ev;
  assign wb_dest    = head_dest;
  assign wb_data    = head_data;
  assign stall      = stall_ev;

  // R5
  stall_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !wb_valid);

  // R5
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> wb_valid);

  // R9
  no_issue_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !mreq_valid);

  // R3
  wb_on_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (head_due == now));

  // R11
  due_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_ev && has_any) |-> (push_due != last_due));
endmodule

// File: tb/fixed_latency_load_buffer_test.sv
module fixed_latency_load_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lat_we = 1'b0;
  logic [3:0]  lat_wdata = '0;
  logic        iss_valid = 1'b0;
  logic [4:0]  iss_dest = '0;
  logic [31:0] iss_addr = '0;
  logic        iss_ready, mreq_valid;
  logic [31:0] mreq_addr;
  logic [2:0]  mreq_tag;
  logic        mrsp_valid = 1'b0;
  logic [2:0]  mrsp_tag = '0;
  logic [31:0] mrsp_data = '0;
  logic        wb_valid, stall;
  logic [4:0]  wb_dest;
  logic [31:0] wb_data;

  fixed_latency_load_buffer uut (
    .clk(clk), .rst_n(rst_n), .lat_we(lat_we), .lat_wdata(lat_wdata),
    .iss_valid(iss_valid), .iss_dest(iss_dest), .iss_addr(iss_addr), .iss_ready(iss_ready),
    .mreq_valid(mreq_valid), .mreq_addr(mreq_addr), .mreq_tag(mreq_tag),
    .mrsp_valid(mrsp_valid), .mrsp_tag(mrsp_tag), .mrsp_data(mrsp_data),
    .wb_valid(wb_valid), .wb_dest(wb_dest), .wb_data(wb_data), .stall(stall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0, stall_seen = 0;
  bit done = 0;

  // Bench model state
  int mt = 0, m_head = 0, m_tail = 0, m_cnt = 0, m_lat = 1;
  bit m_vld [NSLOT];
  bit m_fil [NSLOT];
  int m_dest [NSLOT];
  int m_data [NSLOT];
  int m_due [NSLOT];
  int wb_cyc [32];

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int pick_open();
    int start = int'($urandom % NSLOT);
    for (int k = 0; k < NSLOT; k++) begin
      int s = (start + k) % NSLOT;
      if (m_vld[s] && !m_fil[s]) return s;
    end
    return -1;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp_v, cyc);
    end
  endtask

  task automatic step(input bit iv, input int dest, input bit rv, input int rtag,
                      input int rdata, input bit lw, input int lv);
    bit ex_head, ex_stall, ex_wb, ex_ready, acc;
    int addr, rel;
    addr = int'($urandom);
    iss_valid = iv; iss_dest = dest[4:0]; iss_addr = addr;
    mrsp_valid = rv; mrsp_tag = rtag[2:0]; mrsp_data = rdata;
    lat_we = lw; lat_wdata = lv[3:0];
    #1;
    ex_head  = (m_cnt > 0) && (m_due[m_head] == mt);
    ex_stall = ex_head && !m_fil[m_head];
    ex_wb    = ex_head && m_fil[m_head];
    ex_ready = (m_cnt < NSLOT) && !ex_stall;
    acc      = iv && ex_ready;
    chk("R5", "stall", longint'(stall), longint'(ex_stall));
    chk("R3", "wb_valid", longint'(wb_valid), longint'(ex_wb));
    chk(ex_stall ? "R9" : "R8", "iss_ready", longint'(iss_ready), longint'(ex_ready));
    chk("R10", "mreq_valid", longint'(mreq_valid), longint'(acc));
    if (ex_wb && wb_valid) begin
      chk("R6", "wb_dest", longint'(wb_dest), longint'(m_dest[m_head]));
      chk("R6", "wb_data", longint'(wb_data), longint'(unsigned'(m_data[m_head])));
    end
    if (acc && mreq_valid) begin
      chk("R10", "mreq_tag", longint'(mreq_tag), longint'(m_tail));
      chk("R10", "mreq_addr", longint'(mreq_addr), longint'(unsigned'(addr)));
    end
    if (wb_valid) wb_cyc[wb_dest] = cyc;
    if (stall) stall_seen++;
    // model next state
    rel = m_lat;
    if (m_cnt > 0 && (m_due[(m_tail + NSLOT - 1) % NSLOT] - mt + 1) > rel)
      rel = m_due[(m_tail + NSLOT - 1) % NSLOT] - mt + 1;
    if (ex_wb) begin
      m_vld[m_head] = 0; m_head = (m_head + 1) % NSLOT; m_cnt--;
    end
    if (rv) begin
      m_fil[rtag] = 1; m_data[rtag] = rdata;
    end
    if (acc) begin
      m_vld[m_tail] = 1; m_fil[m_tail] = 0; m_dest[m_tail] = dest; m_due[m_tail] = mt + rel;
      m_tail = (m_tail + 1) % NSLOT; m_cnt++;
    end
    if (lw) m_lat = eff(lv);
    if (!ex_stall) mt++;
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && m_cnt > 0; i++) begin
      int s = pick_open();
      if (s >= 0) step(0, 0, 1, s, int'($urandom), 0, 0);
      else step(0, 0, 0, 0, 0, 0, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c, ta, tb;
    int tags [NSLOT];
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) wb_cyc[i] = -1;
    for (int i = 0; i < NSLOT; i++) begin m_vld[i] = 0; m_fil[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "wb_valid", longint'(wb_valid), 0);
    chk("R1", "stall", longint'(stall), 0);
    chk("R1", "iss_ready", longint'(iss_ready), 1);
    chk("R1", "mreq_valid", longint'(mreq_valid), 0);
    #1;
    idle(2);

    // R4 early data held: latency 6, response one cycle after issue
    step(0, 0, 0, 0, 0, 1, 6);
    c = cyc; ta = m_tail;
    chk("R1", "first tag", longint'(ta), 0);
    step(1, 3, 0, 0, 0, 0, 0);
    step(0, 0, 1, ta, 32'h5A5A_0001, 0, 0);
    idle(8);
    chk("R4", "early wb cycle", longint'(wb_cyc[3]), longint'(c + 6));

    // R2 zero latency acts as one; late arrival costs a stall
    step(0, 0, 0, 0, 0, 1, 0);
    stall_seen = 0;
    c = cyc; ta = m_tail;
    step(1, 4, 0, 0, 0, 0, 0);
    step(0, 0, 1, ta, 32'h0000_0444, 0, 0);
    idle(3);
    chk("R2", "zero-latency wb cycle", longint'(wb_cyc[4]), longint'(c + 2));
    chk("R5", "stall cycles", longint'(stall_seen), 1);

    // R7 starved head, younger load answered early
    step(0, 0, 0, 0, 0, 1, 4);
    c = cyc; ta = m_tail;
    step(1, 5, 0, 0, 0, 0, 0);
    tb = m_tail;
    step(1, 6, 0, 0, 0, 0, 0);
    step(0, 0, 1, tb, 32'h0000_0666, 0, 0);
    idle(3);
    step(0, 0, 1, ta, 32'h0000_0555, 0, 0);
    idle(4);
    chk("R5", "late head wb cycle", longint'(wb_cyc[5]), longint'(c + 7));
    chk("R7", "frozen younger wb cycle", longint'(wb_cyc[6]), longint'(c + 8));

    // R11 latency cut between back-to-back loads; R2 same-cycle write
    step(0, 0, 0, 0, 0, 1, 8);
    c = cyc; ta = m_tail;
    step(1, 7, 0, 0, 0, 1, 1);
    tb = m_tail;
    step(1, 8, 0, 0, 0, 0, 0);
    step(0, 0, 1, ta, 32'h0000_0777, 0, 0);
    step(0, 0, 1, tb, 32'h0000_0888, 0, 0);
    idle(8);
    chk("R2", "write in issue cycle", longint'(wb_cyc[7]), longint'(c + 8));
    chk("R11", "clamped due", longint'(wb_cyc[8]), longint'(c + 9));

    // R8 full ring, R6 reverse answers
    step(0, 0, 0, 0, 0, 1, 15);
    for (int i = 0; i < NSLOT; i++) begin
      tags[i] = m_tail;
      step(1, 10 + i, 0, 0, 0, 0, 0);
    end
    #0;
    chk("R8", "iss_ready when full", longint'(iss_ready), 0);
    step(1, 20, 0, 0, 0, 0, 0);
    for (int i = NSLOT - 1; i >= 0; i--) step(0, 0, 1, tags[i], 1000 + i, 0, 0);
    drain();
    idle(2);
    for (int i = 1; i < NSLOT; i++)
      chk("R6", "issue order", longint'(wb_cyc[10 + i] > wb_cyc[9 + i]), 1);

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      bit lw = ($urandom % 10) == 0;
      bit iv = ($urandom % 2) == 1;
      int s = (($urandom % 10) < 4) ? pick_open() : -1;
      step(iv, int'($urandom % 32), s >= 0, (s >= 0) ? s : 0, int'($urandom),
           lw, int'($urandom % 16));
    end
    drain();
    idle(4);
    chk("R6", "drained", longint'(m_cnt), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule